// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM. The RAM has two chip selects of opposite polarity, separate upper and lower byte selects, and a width pin that switches it between 16-bit words and 8-bit bytes. The host places one request at a time through a valid/ready handshake. The controller produces the strobe sequence on the memory pins, drives the shared data bus through a per-pin output enable, and returns read data with a one-cycle valid pulse.

The length of each access comes from two parameters: the clock period and the speed grade. The grade's cycle time in nanoseconds is divided by the clock period and rounded up. Reads and writes use the same length. In byte mode the address grows by one bit at the bottom, and the controller drives that bit out on the top data pin. The width pin needs a long quiet period with the chip deselected on each side of a change. A runtime change of the mode input therefore stalls the host, keeps the chip deselected through a guard time, flips the width pin, and waits the guard time again before any access.

Top module: `async_sram_ctrl`

## Requirements
- R1: After reset, and whenever no access or mode change is in progress, the chip is deselected (memCs1N=1, memCs2=0), memWeN=1, memOeN=1, data pins 14..0 are not driven, rdValid=0, and memByteN=1 (word mode).
- R2: A word-mode read keeps memCs1N=0, memCs2=1 and memOeN=0 for exactly ACC cycles, where ACC = ceil(cycle ns / CLK_NS) and the cycle is 45 ns with SLOW_GRADE=0 or 55 ns with SLOW_GRADE=1. The cycles start on the edge that accepts the request. memAddr equals reqAddr[19:0]. rdData is memDqIn as sampled at the last access edge, and rdValid is high for exactly the one cycle after that edge.
- R3: A write keeps both chip selects active and memWeN=0 for exactly ACC cycles. memOeN stays 1 throughout. The write data is on memDqOut with its enables on for the whole pulse, and the enables drop together with memWeN.
- R4: In word mode a write drives memLbN=~reqBe[0] and memUbN=~reqBe[1] while the chip is selected. A word read drives both byte selects low.
- R5: In byte mode memAddr=reqAddr[20:1], and pin 15 carries reqAddr[0] and is driven at all times. Write data is reqWdata[7:0] on pins 7..0, and pins 14..8 are never driven. Both byte selects are low during an access, and a read returns {8'h00, memDqIn[7:0]}.
- R6: When modeByte differs from the applied mode, the controller holds reqReady low and the chip deselected for GUARD cycles, then sets memByteN=~modeByte. It holds for another GUARD cycles before it accepts a request. GUARD = ceil(GUARD_NS / CLK_NS).
- R7: Every access is followed by one cycle with the chip deselected before the next access starts. Data pins 14..0 are never driven while memOeN is low.
- R8: reqReady is high only when the controller is idle and modeByte equals the applied mode. A request is taken on a rising edge where reqValid and reqReady are both high. reqReady stays low from that edge until the recovery cycle has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| modeByte | input | 1 | Requested width mode, 1 = byte mode |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Controller can take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 21 | Word address in [19:0], byte address in [20:0] |
| reqWdata | input | 16 | Write data (byte mode uses [7:0]) |
| reqBe | input | 2 | Word-mode write lane enables, bit 1 = upper |
| rdValid | output | 1 | One-cycle pulse: rdData is valid |
| rdData | output | 16 | Read data |
| memAddr | output | 20 | Memory address pins |
| memCs1N | output | 1 | Chip select, active low |
| memCs2 | output | 1 | Chip select, active high |
| memWeN | output | 1 | Write enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memUbN | output | 1 | Upper byte select, active low |
| memLbN | output | 1 | Lower byte select, active low |
| memByteN | output | 1 | Width pin, low = byte mode |
| memDqOut | output | 16 | Data pins, outgoing value |
| memDqOe | output | 16 | Per-pin driver enable for memDqOut |
| memDqIn | input | 16 | Data pins, incoming value |

## Verification
The bench targets requests that arrive while a mode change is pending. A design that let one through would select the chip during the guard window, or with the old width pin. It checks the exact access length on every cycle, so a strobe window one cycle short of the rounded-up count shows up as a timing mismatch. Back-to-back requests test the recovery cycle: a missing idle cycle would turn a write straight into a read and overlap the bus driver with the memory's output enable. Byte-mode transfers at odd and even addresses test that the low address bit reaches pin 15 and that the upper lanes stay off. A wrong mapping would return or write the wrong byte.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  // strobes the sequencer hands to the datapath each cycle
  typedef struct packed {
    logic load;     // latch the incoming request this edge
    logic cs;       // chip selected (access window)
    logic rdOe;     // read access: output enable low
    logic wrEn;     // write access: write strobe low, bus driven
    logic capture;  // sample the data pins this edge
  } strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACC,
    ST_REC,
    ST_MPRE,
    ST_MPOST
  } state_e;

endpackage

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int ACC_CYC   = 5,
  parameter int GUARD_CYC = 20,
  parameter int CNT_W     = 5
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    reqValid,
  input  logic    reqWrite,
  input  logic    modeByte,
  output logic    reqReady,
  output logic    byteMode,
  output strobe_t stb
);

  state_e state;
  logic [CNT_W-1:0] cnt;
  logic wrLat;
  logic curByte;

  assign byteMode = curByte;

  always_comb begin
    reqReady    = (state == ST_IDLE) && (modeByte == curByte);
    stb.load    = reqReady && reqValid;
    stb.cs      = (state == ST_ACC);
    stb.rdOe    = stb.cs && !wrLat;
    stb.wrEn    = stb.cs && wrLat;
    stb.capture = stb.rdOe && (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      wrLat   <= 1'b0;
      curByte <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (modeByte != curByte) begin
            state <= ST_MPRE;
            cnt   <= CNT_W'(GUARD_CYC - 1);
          end else if (reqValid) begin
            state <= ST_ACC;
            cnt   <= CNT_W'(ACC_CYC - 1);
            wrLat <= reqWrite;
          end
        end
        ST_ACC: begin
          if (cnt == '0) state <= ST_REC;
          else           cnt   <= cnt - 1'b1;
        end
        ST_REC: state <= ST_IDLE;
        ST_MPRE: begin
          if (cnt == '0) begin
            curByte <= modeByte;
            state   <= ST_MPOST;
            cnt     <= CNT_W'(GUARD_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_MPOST: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // checker counters for the window properties below
  int runLen;
  int idleRun;
  int sinceMode;
  logic prevByte;

  always_ff @(posedge clk) begin
    if (rst) begin
      runLen    <= 0;
      idleRun   <= GUARD_CYC;
      sinceMode <= GUARD_CYC;
      prevByte  <= 1'b0;
    end else begin
      prevByte <= curByte;
      if (stb.load)    runLen <= 0;
      else if (stb.cs) runLen <= runLen + 1;
      if (stb.cs)                    idleRun <= 0;
      else if (idleRun < GUARD_CYC)  idleRun <= idleRun + 1;
      if (curByte != prevByte)         sinceMode <= 0;
      else if (sinceMode < GUARD_CYC)  sinceMode <= sinceMode + 1;
    end
  end

  // R2 / R3: the access window lasts exactly ACC_CYC cycles
  a_r2_access_length: assert property (@(posedge clk) disable iff (rst)
    $fell(stb.cs) |-> runLen == ACC_CYC);

  // R6: width pin changes only after a full deselected guard period
  a_r6_guard_before_change: assert property (@(posedge clk) disable iff (rst)
    (curByte != prevByte) |-> idleRun >= GUARD_CYC);

  // R6: no select until a full guard period after the width change
  a_r6_guard_after_change: assert property (@(posedge clk) disable iff (rst)
    stb.cs |-> sinceMode >= GUARD_CYC);

  // R8: ready never coexists with an access in flight
  a_r8_ready_idle: assert property (@(posedge clk) disable iff (rst)
    reqReady |-> !stb.cs);

endmodule

// File: rtl/sram_ctl_dp.sv
module sram_ctl_dp
  import sram_ctl_pkg::*;
#(
  parameter int WORD_AW = 20,
  parameter int DW      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic              byteMode,
  input  logic [WORD_AW:0]  reqAddr,
  input  logic [DW-1:0]     reqWdata,
  input  logic [1:0]        reqBe,
  input  logic [DW-1:0]     memDqIn,
  output logic [WORD_AW-1:0] memAddr,
  output logic              memCs1N,
  output logic              memCs2,
  output logic              memWeN,
  output logic              memOeN,
  output logic              memUbN,
  output logic              memLbN,
  output logic              memByteN,
  output logic [DW-1:0]     memDqOut,
  output logic [DW-1:0]     memDqOe,
  output logic              rdValid,
  output logic [DW-1:0]     rdData
);

  localparam int LANE_W = DW / 2;

  logic [WORD_AW:0] aReg;
  logic [DW-1:0]    wdReg;
  logic [1:0]       beReg;
  logic [1:0]       laneSel;

  always_ff @(posedge clk) begin
    if (rst) begin
      aReg  <= '0;
      wdReg <= '0;
      beReg <= '0;
    end else if (stb.load) begin
      aReg  <= reqAddr;
      wdReg <= reqWdata;
      beReg <= reqBe;
    end
  end

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : gLane
      assign laneSel[g] = stb.cs && (byteMode || stb.rdOe || beReg[g]);
    end
  endgenerate

  always_comb begin
    memCs1N  = !stb.cs;
    memCs2   = stb.cs;
    memOeN   = !stb.rdOe;
    memWeN   = !stb.wrEn;
    memLbN   = !laneSel[0];
    memUbN   = !laneSel[1];
    memByteN = !byteMode;
    memAddr  = byteMode ? aReg[WORD_AW:1] : aReg[WORD_AW-1:0];
    if (byteMode) begin
      memDqOut = {aReg[0], {(LANE_W-1){1'b0}}, wdReg[LANE_W-1:0]};
      memDqOe  = {1'b1, {(LANE_W-1){1'b0}}, {LANE_W{stb.wrEn}}};
    end else begin
      memDqOut = wdReg;
      memDqOe  = {DW{stb.wrEn}};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= stb.capture;
      if (stb.capture)
        rdData <= byteMode ? {{LANE_W{1'b0}}, memDqIn[LANE_W-1:0]} : memDqIn;
    end
  end

  // R7: bus drivers below the top pin never overlap the memory's output enable
  a_r7_no_contention: assert property (@(posedge clk) disable iff (rst)
    !memOeN |-> (memDqOe[DW-2:0] == '0));

  // R3: the write strobe appears only inside a selected, output-disabled window
  a_r3_write_in_select: assert property (@(posedge clk) disable iff (rst)
    !memWeN |-> (!memCs1N && memCs2 && memOeN));

  // R2: read-valid is a single-cycle pulse
  a_r2_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    rdValid |=> !rdValid);

  // R6: width pin is steady whenever the chip is selected
  a_r6_width_steady: assert property (@(posedge clk) disable iff (rst)
    !memCs1N |-> $stable(memByteN));

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int CLK_NS     = 10,
  parameter int SLOW_GRADE = 0,
  parameter int GUARD_NS   = 5000000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        modeByte,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        reqWrite,
  input  logic [20:0] reqAddr,
  input  logic [15:0] reqWdata,
  input  logic [1:0]  reqBe,
  output logic        rdValid,
  output logic [15:0] rdData,
  output logic [19:0] memAddr,
  output logic        memCs1N,
  output logic        memCs2,
  output logic        memWeN,
  output logic        memOeN,
  output logic        memUbN,
  output logic        memLbN,
  output logic        memByteN,
  output logic [15:0] memDqOut,
  output logic [15:0] memDqOe,
  input  logic [15:0] memDqIn
);

  localparam int CYC_NS    = (SLOW_GRADE != 0) ? 55 : 45;
  localparam int ACC_CYC   = (CYC_NS + CLK_NS - 1) / CLK_NS;
  localparam int GUARD_CYC = (GUARD_NS + CLK_NS - 1) / CLK_NS;
  localparam int MAX_CYC   = (GUARD_CYC > ACC_CYC) ? GUARD_CYC : ACC_CYC;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  strobe_t stb;
  logic    byteMode;

  sram_ctl_fsm #(
    .ACC_CYC(ACC_CYC), .GUARD_CYC(GUARD_CYC), .CNT_W(CNT_W)
  ) uFsm (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .modeByte(modeByte), .reqReady(reqReady), .byteMode(byteMode), .stb(stb)
  );

  sram_ctl_dp #(.WORD_AW(20), .DW(16)) uDp (
    .clk(clk), .rst(rst), .stb(stb), .byteMode(byteMode),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe), .memDqIn(memDqIn),
    .memAddr(memAddr), .memCs1N(memCs1N), .memCs2(memCs2), .memWeN(memWeN),
    .memOeN(memOeN), .memUbN(memUbN), .memLbN(memLbN), .memByteN(memByteN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .rdValid(rdValid), .rdData(rdData)
  );

endmodule

// File: tb/tb_async_sram_ctrl.sv
module tb_async_sram_ctrl;

  localparam int CLK_NS   = 10;
  localparam int GUARD_NS = 200;
  localparam int ACC      = (45 + CLK_NS - 1) / CLK_NS;
  localparam int GUARD    = (GUARD_NS + CLK_NS - 1) / CLK_NS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic modeByte = 1'b0, reqValid = 1'b0, reqWrite = 1'b0;
  logic [20:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqBe = '0;
  logic reqReady, rdValid, memCs1N, memCs2, memWeN, memOeN, memUbN, memLbN, memByteN;
  logic [15:0] rdData, memDqOut, memDqOe, memDqIn;
  logic [19:0] memAddr;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  async_sram_ctrl #(.CLK_NS(CLK_NS), .SLOW_GRADE(0), .GUARD_NS(GUARD_NS)) dut (
    .clk(clk), .rst(rst), .modeByte(modeByte), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe),
    .rdValid(rdValid), .rdData(rdData), .memAddr(memAddr), .memCs1N(memCs1N),
    .memCs2(memCs2), .memWeN(memWeN), .memOeN(memOeN), .memUbN(memUbN),
    .memLbN(memLbN), .memByteN(memByteN), .memDqOut(memDqOut), .memDqOe(memDqOe),
    .memDqIn(memDqIn)
  );

  // memory stand-in: data pins return a pattern of the address
  function automatic logic [15:0] pat(logic [19:0] a, logic am1, bit bm);
    logic [7:0] lo, hi;
    lo = a[7:0] ^ 8'h3C ^ (bm ? {am1, 7'h00} : 8'h00);
    hi = a[15:8] ^ 8'hA5;
    return {hi, lo};
  endfunction

  assign memDqIn = pat(memAddr, memDqOut[15], !memByteN);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 access, 2 recover, 3 pre-guard, 4 post-guard
  int phase = 0, rem = 0;
  bit mByte = 0, mw = 0, rdPulse = 0;
  logic [20:0] mA;
  logic [15:0] mD, expRd;
  logic [1:0]  mBe;

  always @(posedge clk) begin
    logic [15:0] t;
    if (rst) begin
      phase = 0; mByte = 0; rdPulse = 0;
    end else begin
      rdPulse = 0;
      case (phase)
        0: if (modeByte != mByte) begin phase = 3; rem = GUARD - 1; end
           else if (reqValid) begin
             phase = 1; rem = ACC - 1;
             mw = reqWrite; mA = reqAddr; mD = reqWdata; mBe = reqBe;
           end
        1: if (rem == 0) begin
             phase = 2;
             if (!mw) begin
               rdPulse = 1;
               if (mByte) begin t = pat(mA[20:1], mA[0], 1); expRd = {8'h00, t[7:0]}; end
               else expRd = pat(mA[19:0], 1'b0, 0);
             end
           end else rem--;
        2: phase = 0;
        3: if (rem == 0) begin mByte = modeByte; phase = 4; rem = GUARD - 1; end
           else rem--;
        4: if (rem == 0) phase = 0; else rem--;
        default: phase = 0;
      endcase
    end
    #2;
    if (!rst) compare();
  end

  task automatic compare();
    bit cs;
    string tg;
    logic [15:0] eOe, eOut;
    cs = (phase == 1);
    tg = (phase == 0) ? "R1" : (phase == 1) ? (mw ? "R3" : "R2") : (phase == 2) ? "R7" : "R6";
    chk({tg, " cs1n"}, memCs1N, !cs);
    chk({tg, " cs2"}, memCs2, cs);
    chk({tg, " oen"}, memOeN, !(cs && !mw));
    chk({tg, " wen"}, memWeN, !(cs && mw));
    chk("R6 byten", memByteN, !mByte);
    chk("R8 ready", reqReady, (phase == 0) && (modeByte == mByte));
    chk({tg, " rdvalid"}, rdValid, rdPulse);
    if (rdPulse) chk(mByte ? "R5 rddata" : "R2 rddata", rdData, expRd);
    if (mByte) eOe = {1'b1, 7'h00, {8{cs && mw}}};
    else       eOe = {16{cs && mw}};
    chk(mByte ? "R5 dqoe" : "R7 dqoe", memDqOe, eOe);
    if (mByte) chk("R5 pin15", memDqOut[15], mA[0]);
    if (cs) begin
      chk(mByte ? "R5 addr" : "R2 addr", memAddr, mByte ? mA[20:1] : mA[19:0]);
      chk("R4 lbn", memLbN, !(mByte || !mw || mBe[0]));
      chk("R4 ubn", memUbN, !(mByte || !mw || mBe[1]));
      if (mw) begin
        eOut = mByte ? {mA[0], 7'h00, mD[7:0]} : mD;
        chk(mByte ? "R5 wdata" : "R3 wdata", memDqOut, eOut);
      end
    end
  endtask

  task automatic issue(bit wr, logic [20:0] a, logic [15:0] d, logic [1:0] be);
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d; reqBe = be;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic settle();
    @(negedge clk);
    while (!reqReady) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset cs1n", memCs1N, 1'b1);
    chk("R1 reset byten", memByteN, 1'b1);
    chk("R1 reset ready", reqReady, 1'b1);
    // word-mode writes with every lane pattern
    issue(1, 21'h0_1234, 16'hBEEF, 2'b11); settle();
    issue(1, 21'h0_00FF, 16'h1122, 2'b01); settle();
    issue(1, 21'h0_F0F0, 16'h3344, 2'b10); settle();
    issue(1, 21'h0_0001, 16'h5566, 2'b00); settle();
    // word-mode reads at several addresses
    issue(0, 21'h0_ABCD, 16'h0, 2'b00); settle();
    issue(0, 21'h1_FFFFF, 16'h0, 2'b11); settle();
    // back-to-back write then read (recovery cycle, no contention)
    issue(1, 21'h0_0F00, 16'hA5A5, 2'b11);
    issue(0, 21'h0_0F00, 16'h0, 2'b11);
    settle();
    // mode change with a request already waiting
    @(negedge clk);
    modeByte = 1;
    issue(1, 21'h0_2467, 16'h00C3, 2'b00); settle();
    issue(1, 21'h0_2466, 16'h003C, 2'b11); settle();
    issue(0, 21'h1_0001, 16'h0, 2'b00);
    issue(0, 21'h1_0000, 16'h0, 2'b00);
    settle();
    // back to word mode
    @(negedge clk);
    modeByte = 0;
    issue(0, 21'h0_5A5A, 16'h0, 2'b00); settle();
    repeat (4) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule